// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single words between two independently clocked ports without going through the bulk queue. Port A posts a word into the first mailbox and port B collects it. Port B posts a word into the second mailbox and port A collects it. Each mailbox has an active-low "holding mail" flag. The writer's clock drives it low when it accepts a word. The reader's clock drives it high again when it performs a mailbox read. Because each flag is set in one clock domain and cleared in the other, every mailbox is built as a small two-sided handshake. A writer-side state machine has the states W_IDLE and W_POSTED. A reader-side state machine has the states R_EMPTY and R_HOLD. Requests and acknowledges cross between the two sides as toggles through two-flop synchronizers.

Transitions of the writer machine: W_IDLE to W_POSTED on an accepted mailbox write. W_POSTED to W_IDLE once the synchronized acknowledge toggle equals the request toggle. Transitions of the reader machine: R_EMPTY to R_HOLD once the synchronized request toggle differs from the acknowledge toggle. R_HOLD to R_EMPTY on a mailbox read, which also flips the acknowledge toggle. Each mailbox shows its flag on both sides: the writer-side copy follows W_IDLE and the reader-side copy follows R_EMPTY.

Port B's registered read data is a multiplexer. It carries the first mailbox when the mailbox select is high and the word on the queue-data input when the select is low.

Top module: `mbox_pair`

## Requirements
- R1: While `rst_n` is low, all four flag outputs are high (no mail held).
- R2: A port does nothing on a rising edge unless its `*_sel_n` is 0 and its `*_en` is 1 at that edge. Without an access, flags and read data are unchanged.
- R3: An access with `a_mb`=1 and `a_wr`=1 while `a_mb1_full_n` is high stores `a_din` in mailbox 1 and drives `a_mb1_full_n` low on that same clk_a edge.
- R4: After the clk_a edge that accepts a mailbox-1 write, `b_mb1_full_n` goes low on the third clk_b rising edge. When edges nearly coincide, this is between the second and fourth edge.
- R5: A port-B access with `b_mb`=1 and `b_wr`=0 while `b_mb1_full_n` is low loads `b_dout` with the mailbox-1 word and drives `b_mb1_full_n` high on that clk_b edge. `a_mb1_full_n` then returns high within two to four clk_a edges.
- R6: A mailbox write attempted while the writer-side flag of that mailbox is low is ignored: the stored word and the flags are unchanged.
- R7: A port-B access with `b_mb`=0 and `b_wr`=0 loads `b_dout` with `b_fifo_din` and leaves both mailboxes unchanged.
- R8: Mailbox 2 mirrors mailbox 1 with the ports swapped. A port-B write (`b_mb`=1, `b_wr`=1) drives `b_mb2_full_n` low at once, and `a_mb2_full_n` low two to four clk_a edges later. A port-A read (`a_mb`=1, `a_wr`=0) loads `a_dout` with the word and drives `a_mb2_full_n` high. `b_mb2_full_n` then returns high within two to four clk_b edges.
- R9: A mailbox read while the reader-side flag is high returns the last word stored in that mailbox and leaves every flag high.
- R10: Every word read from a mailbox equals, bit for bit, the word whose write set its flag. This holds for all 36 bit positions in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| a_sel_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable, active high |
| a_mb | input | 1 | Port A mailbox select |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A read data (mailbox 2) |
| b_sel_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable, active high |
| b_mb | input | 1 | Port B mailbox select |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_din | input | W | Port B write data |
| b_fifo_din | input | W | Queue data presented to port B |
| b_dout | output | W | Port B read data (mailbox 1 or queue data) |
| a_mb1_full_n | output | 1 | Mailbox 1 flag, clk_a side |
| b_mb1_full_n | output | 1 | Mailbox 1 flag, clk_b side |
| b_mb2_full_n | output | 1 | Mailbox 2 flag, clk_b side |
| a_mb2_full_n | output | 1 | Mailbox 2 flag, clk_a side |

## Verification
The hardest state to reach from the ports is a mailbox whose flag is low on the writer side while the reader side still shows it high or has already cleared it. Only in that state does a second write have to be refused. Only through that state does the round trip of the acknowledge toggle become visible. The stimulus gets there by running the two clocks at periods with no simple ratio. After every write, it counts reader edges until the far flag moves. It tries a second write while the writer flag is still low. It then counts writer edges after the read until the writer flag recovers. A walking-one sweep over all 36 bits in both directions, plus a sweep over every select/enable/direction combination, covers the data path and the access qualification.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    typedef enum logic {W_IDLE = 1'b0, W_POSTED = 1'b1} wr_state_t;
    typedef enum logic {R_EMPTY = 1'b0, R_HOLD = 1'b1} rd_state_t;
endpackage

// File: rtl/mbox_writer.sv
`timescale 1ns/1ps
module mbox_writer
    import mbox_pkg::*;
#(
    parameter int W = 36,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         put,
    input  logic [W-1:0] put_data,
    input  logic         ack_tog,
    output logic         req_tog,
    output logic [W-1:0] word,
    output logic         empty_n_flag
);
    localparam int SL = SYNC - 1;

    wr_state_t      st, st_nx;
    logic [SL:0]    ack_sync;
    logic           take;

    assign take = (st == W_IDLE) && put;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= W_IDLE;
            ack_sync <= '0;
            req_tog  <= 1'b0;
            word     <= '0;
        end else begin
            st       <= st_nx;
            ack_sync <= {ack_sync[SL-1:0], ack_tog};
            if (take) begin
                word    <= put_data;
                req_tog <= ~req_tog;
            end
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE:   if (put) st_nx = W_POSTED;
            W_POSTED: if (ack_sync[SL] == req_tog) st_nx = W_IDLE;
        endcase
    end

    // outputs
    always_comb empty_n_flag = (st == W_IDLE);
endmodule

// File: rtl/mbox_reader.sv
`timescale 1ns/1ps
module mbox_reader
    import mbox_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic req_tog,
    output logic ack_tog,
    output logic empty_n_flag
);
    localparam int SL = SYNC - 1;

    rd_state_t   st, st_nx;
    logic [SL:0] req_sync;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= R_EMPTY;
            req_sync <= '0;
            ack_tog  <= 1'b0;
        end else begin
            st       <= st_nx;
            req_sync <= {req_sync[SL-1:0], req_tog};
            if ((st == R_HOLD) && take) ack_tog <= ~ack_tog;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            R_EMPTY: if (req_sync[SL] != ack_tog) st_nx = R_HOLD;
            R_HOLD:  if (take) st_nx = R_EMPTY;
        endcase
    end

    // outputs
    always_comb empty_n_flag = (st == R_EMPTY);
endmodule

// File: rtl/mbox_pair.sv
`timescale 1ns/1ps
module mbox_pair #(
    parameter int W = 36,
    parameter int SYNC = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_sel_n,
    input  logic         a_en,
    input  logic         a_mb,
    input  logic         a_wr,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    input  logic         b_sel_n,
    input  logic         b_en,
    input  logic         b_mb,
    input  logic         b_wr,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_din,
    output logic [W-1:0] b_dout,
    output logic         a_mb1_full_n,
    output logic         b_mb1_full_n,
    output logic         b_mb2_full_n,
    output logic         a_mb2_full_n
);
    logic         a_acc, b_acc;
    logic         a_put, a_take, b_put, b_take, b_read;
    logic         m1_req, m1_ack, m2_req, m2_ack;
    logic [W-1:0] m1_word, m2_word;

    assign a_acc  = !a_sel_n && a_en;
    assign b_acc  = !b_sel_n && b_en;
    assign a_put  = a_acc && a_mb && a_wr;
    assign a_take = a_acc && a_mb && !a_wr;
    assign b_put  = b_acc && b_mb && b_wr;
    assign b_read = b_acc && !b_wr;
    assign b_take = b_read && b_mb;

    // mailbox 1: A writes, B reads
    mbox_writer #(.W(W), .SYNC(SYNC)) u_m1_wr (
        .clk(clk_a), .rst_n(rst_n), .put(a_put), .put_data(a_din),
        .ack_tog(m1_ack), .req_tog(m1_req), .word(m1_word),
        .empty_n_flag(a_mb1_full_n));

    mbox_reader #(.SYNC(SYNC)) u_m1_rd (
        .clk(clk_b), .rst_n(rst_n), .take(b_take), .req_tog(m1_req),
        .ack_tog(m1_ack), .empty_n_flag(b_mb1_full_n));

    // mailbox 2: B writes, A reads
    mbox_writer #(.W(W), .SYNC(SYNC)) u_m2_wr (
        .clk(clk_b), .rst_n(rst_n), .put(b_put), .put_data(b_din),
        .ack_tog(m2_ack), .req_tog(m2_req), .word(m2_word),
        .empty_n_flag(b_mb2_full_n));

    mbox_reader #(.SYNC(SYNC)) u_m2_rd (
        .clk(clk_a), .rst_n(rst_n), .take(a_take), .req_tog(m2_req),
        .ack_tog(m2_ack), .empty_n_flag(a_mb2_full_n));

    // read data registers
    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n)      a_dout <= '0;
        else if (a_take) a_dout <= m2_word;
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n)      b_dout <= '0;
        else if (b_read) b_dout <= b_mb ? m1_word : b_fifo_din;
    end
endmodule

// File: rtl/mbox_pair_checks.sv
`timescale 1ns/1ps
module mbox_pair_checks #(
    parameter int W = 36
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst_n,
    input logic         a_sel_n,
    input logic         a_en,
    input logic         a_mb,
    input logic         a_wr,
    input logic [W-1:0] a_din,
    input logic [W-1:0] a_dout,
    input logic         b_sel_n,
    input logic         b_en,
    input logic         b_mb,
    input logic         b_wr,
    input logic [W-1:0] b_din,
    input logic [W-1:0] b_fifo_din,
    input logic [W-1:0] b_dout,
    input logic         a_mb1_full_n,
    input logic         b_mb1_full_n,
    input logic         b_mb2_full_n,
    input logic         a_mb2_full_n
);
    // R1 checked mid-cycle, after the first edge has applied the reset
    always_ff @(negedge clk_a) begin
        if (!rst_n) a_r1_reset_flags_a: assert (a_mb1_full_n && a_mb2_full_n);
    end
    always_ff @(negedge clk_b) begin
        if (!rst_n) a_r1_reset_flags_b: assert (b_mb1_full_n && b_mb2_full_n);
    end

    a_r2_no_access_keeps_flag: assert property (@(posedge clk_a) disable iff (!rst_n)
        ((a_sel_n || !a_en) && a_mb1_full_n) |=> a_mb1_full_n);

    a_r3_write_sets_flag: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!a_sel_n && a_en && a_mb && a_wr && a_mb1_full_n) |=> !a_mb1_full_n);

    a_r5_read_clears_flag: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_sel_n && b_en && b_mb && !b_wr && !b_mb1_full_n) |=> b_mb1_full_n);

    a_r7_queue_path: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_sel_n && b_en && !b_mb && !b_wr) |=> (b_dout == $past(b_fifo_din)));

    a_r8_b_write_sets_flag: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_sel_n && b_en && b_mb && b_wr && b_mb2_full_n) |=> !b_mb2_full_n);

    a_r8_a_read_clears_flag: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!a_sel_n && a_en && a_mb && !a_wr && !a_mb2_full_n) |=> a_mb2_full_n);
endmodule

bind mbox_pair mbox_pair_checks #(.W(W)) u_chk (.*);

// File: tb/test_mbox_pair.sv
`timescale 1ns/1ps
module test_mbox_pair;
    localparam int W = 36;

    logic         clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic         a_sel_n = 1'b1, a_en = 1'b0, a_mb = 1'b0, a_wr = 1'b0;
    logic         b_sel_n = 1'b1, b_en = 1'b0, b_mb = 1'b0, b_wr = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0, b_fifo_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_mb1_full_n, b_mb1_full_n, b_mb2_full_n, a_mb2_full_n;

    int checks = 0;
    int fails  = 0;

    always #2    clk_a = ~clk_a;   // 250 MHz
    always #3.65 clk_b = ~clk_b;   // unrelated period

    mbox_pair #(.W(W)) i_mbox_pair (.*);

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one port-A cycle; returns 0.5 ns after the active edge
    task automatic a_op(input bit sel_n, input bit en, input bit mb, input bit wr, input logic [W-1:0] d);
        @(negedge clk_a);
        a_sel_n = sel_n; a_en = en; a_mb = mb; a_wr = wr; a_din = d;
        @(posedge clk_a); #0.5;
        a_sel_n = 1'b1; a_en = 1'b0;
    endtask

    task automatic b_op(input bit sel_n, input bit en, input bit mb, input bit wr, input logic [W-1:0] d);
        @(negedge clk_b);
        b_sel_n = sel_n; b_en = en; b_mb = mb; b_wr = wr; b_din = d;
        @(posedge clk_b); #0.5;
        b_sel_n = 1'b1; b_en = 1'b0;
    endtask

    // count edges of the far clock until a flag reaches a level
    task automatic wait_b(input int which, input bit lvl, output int n);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk_b); #0.5; n++;
            if ((which == 1 ? b_mb1_full_n : b_mb2_full_n) == lvl) break;
        end
    endtask

    task automatic wait_a(input int which, input bit lvl, output int n);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk_a); #0.5; n++;
            if ((which == 1 ? a_mb1_full_n : a_mb2_full_n) == lvl) break;
        end
    endtask

    // full round trip through mailbox 1 (A to B)
    task automatic send_m1(input logic [W-1:0] v);
        int n;
        a_op(0, 1, 1, 1, v);
        chk(a_mb1_full_n == 1'b0, "R3 a-side flag low on write edge", W'(a_mb1_full_n), '0);
        wait_b(1, 1'b0, n);
        chk(n >= 2 && n <= 4, "R4 b-side flag latency", W'(n), W'(3));
        a_op(0, 1, 1, 1, ~v);
        chk(a_mb1_full_n == 1'b0, "R6 flag held after refused write", W'(a_mb1_full_n), '0);
        b_op(0, 1, 1, 0, '0);
        chk(b_dout == v, "R10 mailbox-1 data", b_dout, v);
        chk(b_mb1_full_n == 1'b1, "R5 b-side flag high after read", W'(b_mb1_full_n), W'(1));
        wait_a(1, 1'b1, n);
        chk(n >= 2 && n <= 4, "R5 a-side flag recovery", W'(n), W'(3));
    endtask

    task automatic send_m2(input logic [W-1:0] v);
        int n;
        b_op(0, 1, 1, 1, v);
        chk(b_mb2_full_n == 1'b0, "R8 b-side flag low on write edge", W'(b_mb2_full_n), '0);
        wait_a(2, 1'b0, n);
        chk(n >= 2 && n <= 4, "R8 a-side flag latency", W'(n), W'(3));
        b_op(0, 1, 1, 1, ~v);
        chk(b_mb2_full_n == 1'b0, "R6 mailbox-2 refused write", W'(b_mb2_full_n), '0);
        a_op(0, 1, 1, 0, '0);
        chk(a_dout == v, "R10 mailbox-2 data", a_dout, v);
        chk(a_mb2_full_n == 1'b1, "R8 a-side flag high after read", W'(a_mb2_full_n), W'(1));
        wait_b(2, 1'b1, n);
        chk(n >= 2 && n <= 4, "R8 b-side flag recovery", W'(n), W'(3));
    endtask

    initial begin
        logic [W-1:0] pat;
        repeat (4) @(posedge clk_b);
        @(negedge clk_a);
        chk(a_mb1_full_n && b_mb1_full_n && a_mb2_full_n && b_mb2_full_n, "R1 flags during reset", '0, '0);
        chk(a_dout == '0 && b_dout == '0, "R1 read data during reset", a_dout | b_dout, '0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk_a);

        // R2: every non-access combination of select/enable with a mailbox write
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue; // sel_n=0, en=1 is the only access
            a_op(c[1], c[0], 1, 1, 36'h5A5A5A5A5);
            repeat (6) @(posedge clk_b); #0.5;
            chk(a_mb1_full_n && b_mb1_full_n, "R2 no access leaves mailbox 1 empty", W'(a_mb1_full_n), W'(1));
        end

        // R9: read of an empty mailbox after one transfer
        send_m1(36'h123456789);
        b_op(0, 1, 1, 0, '0);
        chk(b_dout == 36'h123456789, "R9 empty read returns last word", b_dout, 36'h123456789);
        chk(a_mb1_full_n && b_mb1_full_n, "R9 empty read leaves flags high", W'(b_mb1_full_n), W'(1));

        // R7: queue path on port B, mailbox 1 untouched
        for (int k = 0; k < 4; k++) begin
            pat = 36'h0F0F0F0F0 ^ (W'(k) * 36'h111111111);
            b_fifo_din = pat;
            b_op(0, 1, 0, 0, '0);
            chk(b_dout == pat, "R7 queue word on b_dout", b_dout, pat);
            chk(a_mb1_full_n && b_mb1_full_n, "R7 mailbox flags unchanged", W'(b_mb1_full_n), W'(1));
        end

        // R2 on port B: non-access read of a full mailbox keeps it full
        a_op(0, 1, 1, 1, 36'hABCDEF012);
        begin
            int n;
            wait_b(1, 1'b0, n);
        end
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            b_op(c[1], c[0], 1, 0, '0);
            chk(b_mb1_full_n == 1'b0, "R2 no access keeps mailbox 1 full", W'(b_mb1_full_n), '0);
        end
        b_op(0, 1, 1, 0, '0);
        chk(b_dout == 36'hABCDEF012, "R10 data after held period", b_dout, 36'hABCDEF012);
        repeat (6) @(posedge clk_a);

        // R10: walking one in both directions
        for (int i = 0; i < W; i++) begin
            send_m1(W'(1) << i);
            send_m2(~(W'(1) << i));
        end

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule